// File: doc/BRIEF.md
# Configurable Output Cell for a Programmable Logic Array

This block is one output cell of a small programmable sum-of-products device. An external AND array hands it a vector of product-term bits. The cell ORs the enabled terms into one sum. It can then store that sum in a rising-edge D flip-flop or pass it straight through, and it can invert the chosen value before it drives the pin. A separate product term controls the pin's output enable. The pin is bidirectional and is modelled as three signals: a driven value, an enable and the observed pin level. The cell also returns a feedback bit to the array.

Two configuration bits select the mode. Each bit reads 1 when it is left unprogrammed, so a blank cell comes up combinatorial and active-high. In registered modes the feedback is the flip-flop output, taken before the polarity inversion. In combinatorial modes the feedback is the observed pin level, so a disabled pin works as an input. An asynchronous clear term and a synchronous set term act on the flip-flop. The clear wins when both are active.

The cell has no data stream. Every pin is a plain level, and there is no handshake or back-pressure.

Top module: `pal_out_cell`

## Requirements
- R1: The sum is the OR of product-term bits 0 to NUM_TERMS-1. Bits at index NUM_TERMS and above never affect any output.
- R2: With clear and set both inactive, the flip-flop takes the sum on each rising clock edge.
- R3: While the clear input is 1, the flip-flop is 0 immediately, without waiting for a clock edge. Clear overrides set.
- R4: With clear inactive and set at 1, the flip-flop becomes 1 at the next rising edge.
- R5: Mode bypass=0, true=0 (registered, active-low): the driven pin value is the inverse of the flip-flop.
- R6: Mode bypass=0, true=1 (registered, active-high): the driven pin value equals the flip-flop.
- R7: Mode bypass=1 gives a combinatorial output: the driven value is the sum when true=1 and the inverted sum when true=0, in the same cycle. The unprogrammed setting 1,1 is combinatorial, active-high.
- R8: When bypass=0, the feedback equals the flip-flop output, taken before the polarity inversion.
- R9: When bypass=1, the feedback equals the observed pin level. With the output disabled, that level is whatever the outside drives.
- R10: The pin output enable follows the output-enable term combinationally in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the flip-flop loads on the rising edge |
| arst_i | input | 1 | Asynchronous clear term, active high |
| spre_i | input | 1 | Synchronous set term, active high |
| terms_i | input | 16 | Product-term bits from the AND array |
| oe_term_i | input | 1 | Output-enable product term |
| cfg_bypass_i | input | 1 | 1 = combinatorial path, 0 = registered path (1 when unprogrammed) |
| cfg_true_i | input | 1 | 1 = active-high, 0 = active-low (1 when unprogrammed) |
| pin_in_i | input | 1 | Observed level on the pin |
| pin_out_o | output | 1 | Value the cell drives onto the pin |
| pin_oe_o | output | 1 | Pin output enable |
| fb_o | output | 1 | Feedback to the array |

## Verification
Combinatorial results are due in the same cycle as their stimulus: the pin value in bypass modes, the enable, and the feedback taken from the pin. The bench drives inputs on the falling edge and samples 1 ns later. Register results are due one rising edge after the stimulus. The bench advances its own flip-flop model at that edge and samples 1 ns after it. The asynchronous clear is checked in the falling-edge slot where it is raised, before any rising edge has passed. The sweep covers all four modes, with single-term, high-index and mixed term patterns. It also covers both enable states, both external pin levels, and the set and clear terms, including both at once.

// File: rtl/pal_cell_pkg.sv
package pal_cell_pkg;
  localparam int unsigned MAX_TERMS = 16;

  typedef struct packed {
    logic use_reg;
    logic invert;
  } cell_cfg_t;
endpackage

// File: rtl/pal_term_or.sv
module pal_term_or #(
  parameter int unsigned WIDTH     = 16,
  parameter int unsigned NUM_TERMS = 16
) (
  input  logic [WIDTH-1:0] terms_i,
  output logic             sum_o
);
  logic [WIDTH-1:0] used_w;

  for (genvar g = 0; g < WIDTH; g++) begin : g_mask
    if (g < NUM_TERMS) begin : g_live
      assign used_w[g] = terms_i[g];
    end else begin : g_tied
      assign used_w[g] = 1'b0;
    end
  end

  assign sum_o = |used_w;
endmodule

// File: rtl/pal_cfg_decode.sv
module pal_cfg_decode
  import pal_cell_pkg::*;
(
  input  logic      bypass_i,
  input  logic      true_i,
  output cell_cfg_t cfg_o
);
  always_comb begin
    cfg_o.use_reg = ~bypass_i;
    cfg_o.invert  = ~true_i;
  end
endmodule

// File: rtl/pal_cell_reg.sv
module pal_cell_reg (
  input  logic clk_i,
  input  logic arst_i,
  input  logic spre_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i)      q_o <= 1'b0;
    else if (spre_i) q_o <= 1'b1;
    else             q_o <= d_i;
  end
endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell
  import pal_cell_pkg::*;
#(
  parameter int unsigned NUM_TERMS = 16
) (
  input  logic                 clk_i,
  input  logic                 arst_i,
  input  logic                 spre_i,
  input  logic [MAX_TERMS-1:0] terms_i,
  input  logic                 oe_term_i,
  input  logic                 cfg_bypass_i,
  input  logic                 cfg_true_i,
  input  logic                 pin_in_i,
  output logic                 pin_out_o,
  output logic                 pin_oe_o,
  output logic                 fb_o
);
  logic      sum_w;
  logic      q_w;
  logic      sel_w;
  cell_cfg_t cfg_w;

  pal_term_or #(.WIDTH(MAX_TERMS), .NUM_TERMS(NUM_TERMS)) u_or (
    .terms_i (terms_i),
    .sum_o   (sum_w)
  );

  pal_cfg_decode u_dec (
    .bypass_i (cfg_bypass_i),
    .true_i   (cfg_true_i),
    .cfg_o    (cfg_w)
  );

  pal_cell_reg u_reg (
    .clk_i  (clk_i),
    .arst_i (arst_i),
    .spre_i (spre_i),
    .d_i    (sum_w),
    .q_o    (q_w)
  );

  always_comb begin
    sel_w     = cfg_w.use_reg ? q_w : sum_w;
    pin_out_o = sel_w ^ cfg_w.invert;
    pin_oe_o  = oe_term_i;
    fb_o      = cfg_w.use_reg ? q_w : pin_in_i;
  end
endmodule

// File: rtl/pal_out_cell_chk.sv
module pal_out_cell_chk (
  input logic clk_i,
  input logic arst_i,
  input logic spre_i,
  input logic oe_term_i,
  input logic cfg_bypass_i,
  input logic cfg_true_i,
  input logic pin_in_i,
  input logic pin_out_o,
  input logic pin_oe_o,
  input logic fb_o,
  input logic sum_i,
  input logic q_i
);
  // R2: with no set, the register holds last cycle's sum
  p_load_r2: assert property (@(posedge clk_i) disable iff (arst_i)
    !spre_i |=> (q_i == $past(sum_i)));

  // R4: set forces a 1 at the next edge
  p_preset_r4: assert property (@(posedge clk_i) disable iff (arst_i)
    spre_i |=> q_i);

  // R3: clear holds the register at 0
  p_clear_r3: assert property (@(posedge clk_i)
    arst_i |-> !q_i);

  // R8: registered feedback is the un-inverted register
  p_fb_reg_r8: assert property (@(posedge clk_i) disable iff (arst_i)
    !cfg_bypass_i |-> (fb_o == q_i));

  // R9: combinatorial feedback is the pin
  p_fb_pin_r9: assert property (@(posedge clk_i) disable iff (arst_i)
    cfg_bypass_i |-> (fb_o == pin_in_i));

  // R7: combinatorial output tracks the sum with polarity
  p_comb_r7: assert property (@(posedge clk_i) disable iff (arst_i)
    cfg_bypass_i |-> (pin_out_o == (cfg_true_i ? sum_i : !sum_i)));

  // R10: enable follows its term
  p_oe_r10: assert property (@(posedge clk_i) disable iff (arst_i)
    pin_oe_o == oe_term_i);
endmodule

bind pal_out_cell pal_out_cell_chk u_chk (
  .clk_i        (clk_i),
  .arst_i       (arst_i),
  .spre_i       (spre_i),
  .oe_term_i    (oe_term_i),
  .cfg_bypass_i (cfg_bypass_i),
  .cfg_true_i   (cfg_true_i),
  .pin_in_i     (pin_in_i),
  .pin_out_o    (pin_out_o),
  .pin_oe_o     (pin_oe_o),
  .fb_o         (fb_o),
  .sum_i        (sum_w),
  .q_i          (q_w)
);

// File: tb/pal_out_cell_tb_top.sv
module pal_out_cell_tb_top;
  localparam int unsigned NT = 12;
  localparam logic [15:0] MASK = 16'h0FFF;

  logic        clk = 1'b0;
  logic        arst = 1'b1;
  logic        spre = 1'b0;
  logic [15:0] terms = '0;
  logic        oe = 1'b0;
  logic        byp = 1'b0;
  logic        tru = 1'b1;
  logic        ext = 1'b0;
  logic        pin_w, pout, poe, fb;
  logic        exp_q = 1'b0;
  int          nchk = 0;
  int          nerr = 0;

  always #5 clk = ~clk;

  assign pin_w = poe ? pout : ext;

  pal_out_cell #(.NUM_TERMS(NT)) dut_i (
    .clk_i(clk), .arst_i(arst), .spre_i(spre), .terms_i(terms),
    .oe_term_i(oe), .cfg_bypass_i(byp), .cfg_true_i(tru),
    .pin_in_i(pin_w), .pin_out_o(pout), .pin_oe_o(poe), .fb_o(fb)
  );

  task automatic chk(string req, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0b exp=%0b mode=%0b%0b", req, act, exp, byp, tru);
    end
  endtask

  function automatic logic exp_sum(logic [15:0] t);
    return |(t & MASK);
  endfunction

  task automatic check_all(string reg_tag);
    logic s, sel, o, p;
    s   = exp_sum(terms);
    sel = byp ? s : exp_q;
    o   = tru ? sel : ~sel;
    p   = oe ? o : ext;
    if (byp) chk((terms & ~MASK) != 0 ? "R1/R7" : "R7", pout, o);
    else     chk(reg_tag, pout, o);
    chk("R10", poe, oe);
    if (byp) chk("R9", fb, p);
    else     chk("R8", fb, exp_q);
  endtask

  task automatic step(logic [15:0] t, logic o, logic e, logic ar, logic sp);
    string tag;
    @(negedge clk);
    terms = t; oe = o; ext = e; arst = ar; spre = sp;
    if (ar) exp_q = 1'b0;
    #1;
    tag = ar ? "R3" : (tru ? "R6" : "R5");
    check_all(tag);
    @(posedge clk);
    exp_q = ar ? 1'b0 : (sp ? 1'b1 : exp_sum(t));
    tag = ar ? "R3" : (sp ? "R4" : "R2");
    #1;
    check_all(tag);
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // reset state, registered active-high
    chk("R3", pout, 1'b0);
    chk("R8", fb, 1'b0);
    @(negedge clk);
    arst = 1'b0;
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      byp = m[1]; tru = m[0];
      for (int i = 0; i < 48; i++) begin
        logic [15:0] t;
        t = (i < 16) ? 16'(1 << i) : (i == 16 ? 16'h0000 : 16'((i * 37) ^ (i << 5)));
        step(t, i[0] ^ i[2], i[1], (i % 11) == 5, (i % 7) == 3);
      end
    end
    // clear raised between edges with set also active
    @(negedge clk);
    byp = 1'b0; tru = 1'b1;
    step(16'h0001, 1'b1, 1'b0, 1'b0, 1'b1);
    step(16'h0000, 1'b1, 1'b0, 1'b1, 1'b1);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule